// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Frame-Error Flag

This block is the receive half of a classic microcontroller-style asynchronous serial port. It works from a 16x sample enable that an external rate generator supplies. It waits for a falling edge on the serial line and checks that the start bit is still low at its centre. It then gathers 8 data bits (mode 1) or 9 data bits (modes 2 and 3), least significant bit first. Each bit is decided by a majority vote of three samples taken near its centre. When a frame completes, the block raises a receive-complete flag. Software reads the byte from a data register and reads the ninth bit from the control register.

Software reaches the block through three byte-wide registers: control (address 0), configuration (address 1) and received data (address 2). The configuration register holds a frame-check enable. While that enable is low, control bit 7 is the upper mode-select bit. While it is high, the same bit position shows a sticky framing-error flag instead, and the receive-complete flag moves from the centre of the last data bit to the centre of the stop bit.

Top module: `uart_rx_fe`

## Requirements
- R1: After reset, the control, configuration and data registers all read 0x00 and no reception is in progress.
- R2: In mode 1 (control bits 7:6 = 01), a frame carries a start bit, 8 data bits LSB first and a stop bit. The data bits land in the data register (address 2) and set control bit 0 (receive-complete).
- R3: In modes 2 and 3 (control bit 7 = 1), a frame carries 9 data bits. Bits 0 to 7 go to the data register and the ninth bit goes to control bit 2. Mode 1 frames leave control bit 2 unchanged.
- R4: Each bit is the majority of three samples taken at sample counts 7, 8 and 9 of its 16. A one-sample disturbance inside that window does not change the received value.
- R5: Reception starts on a high-to-low transition of the line. If the start bit reads high at its centre, the receiver drops the frame and returns to idle without changing any register.
- R6: With the frame check disabled (configuration bit 6 = 0), receive-complete rises at the centre of the last data bit. With it enabled, receive-complete rises at the centre of the stop bit.
- R7: With the frame check enabled, a stop bit that votes 0 sets the framing-error flag. With the check disabled, no frame sets it.
- R8: Once set, the framing-error flag stays set through later frames with good stop bits. Only writing 0 to control bit 7 while the check is enabled, or a reset, clears it. Writing 1 to that bit does not change it.
- R9: While the check is disabled, control bit 7 reads and writes the upper mode bit. While it is enabled, bit 7 reads the framing-error flag, and writes to bit 7 leave the mode bit unchanged.
- R10: Receive-complete is cleared only by writing 0 to control bit 0, and writing 1 does not set it. A frame that arrives while the flag is set still overwrites the data register.
- R11: Nothing is received while the receive enable (control bit 4) is 0 or the mode bits are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-cycle enable, 16 per bit time |
| reg_addr | input | 2 | Register select: 0 control, 1 configuration, 2 data |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |

## Verification
The serial line passes through two synchronizer flops before the vote. Each bit's decision is therefore ready about nine sample ticks plus two clocks after the bit edge, and the register flags update one clock after that. The bench drives every bit for a full bit time and waits out the whole stop bit and an idle gap before it reads any result. The one timing-sensitive check, the position of receive-complete, is sampled a quarter bit into the stop bit. By then the decision on the last data bit has landed, and the stop-bit decision cannot yet have landed. Register reads are combinational and are sampled one nanosecond after the falling clock edge.

// File: rtl/uart_rx_fe.sv
module uart_rx_fe #(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       tick16,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] S_A  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] S_B  = CW'(OVS/2);
  localparam logic [CW-1:0] S_C  = CW'(OVS/2 + 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} st_t;

  st_t st;
  logic [SYNC-1:0] sync_q;
  logic [CW-1:0] cnt;
  logic [3:0] idx;
  logic [8:0] sh, sh_nx, cap_word;
  logic sa, sb, rx_q;
  logic mode_hi, mode_lo, rx_en, fe_en, fe, done, bit8;
  logic [7:0] rbuf;

  wire rx_s    = sync_q[SYNC-1];
  wire vote    = (sa & sb) | (sa & rx_s) | (sb & rx_s);
  wire nine    = mode_hi;
  wire enabled = rx_en & (mode_hi | mode_lo);
  wire [3:0] last_idx = nine ? 4'd8 : 4'd7;
  wire mid     = tick16 && st != IDLE && cnt == S_C;
  wire cap     = mid && ((st == DATA && idx == last_idx && !fe_en) || (st == STOP && fe_en));
  wire fe_set  = mid && st == STOP && fe_en && !vote;
  wire wr_ctl  = reg_wr && reg_addr == 2'd0;
  wire wr_cfg  = reg_wr && reg_addr == 2'd1;

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[5], reg_wdata[3:1]};

  always_comb begin
    sh_nx = sh;
    sh_nx[idx] = vote;
    cap_word = (st == DATA) ? sh_nx : sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], rx_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; idx <= '0; sh <= '0;
      sa <= 1'b1; sb <= 1'b1; rx_q <= 1'b1;
    end else if (tick16) begin
      rx_q <= rx_s;
      if (st == IDLE) begin
        if (enabled && rx_q && !rx_s) begin
          st  <= START;
          cnt <= CW'(1);
        end
      end else begin
        cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
        if (cnt == S_A) sa <= rx_s;
        if (cnt == S_B) sb <= rx_s;
        if (cnt == S_C) begin
          case (st)
            START:   if (vote) st <= IDLE;
            DATA:    sh <= sh_nx;
            default: st <= IDLE;
          endcase
        end
        if (cnt == LAST) begin
          if (st == START) begin
            st  <= DATA;
            idx <= '0;
          end else if (st == DATA) begin
            if (idx == last_idx) st <= STOP;
            else idx <= idx + 4'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_hi <= 1'b0; mode_lo <= 1'b0; rx_en <= 1'b0; fe_en <= 1'b0;
      fe <= 1'b0; done <= 1'b0; bit8 <= 1'b0; rbuf <= '0;
    end else begin
      if (wr_ctl) begin
        mode_lo <= reg_wdata[6];
        rx_en   <= reg_wdata[4];
        if (!fe_en) mode_hi <= reg_wdata[7];
      end
      if (wr_cfg) fe_en <= reg_wdata[6];
      if (fe_set) fe <= 1'b1;
      else if (wr_ctl && fe_en && !reg_wdata[7]) fe <= 1'b0;
      if (cap) done <= 1'b1;
      else if (wr_ctl && !reg_wdata[0]) done <= 1'b0;
      if (cap) begin
        rbuf <= cap_word[7:0];
        if (nine) bit8 <= cap_word[8];
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {fe_en ? fe : mode_hi, mode_lo, 1'b0, rx_en, 1'b0, bit8, 1'b0, done};
      2'd1:    reg_rdata = {1'b0, fe_en, 6'b0};
      2'd2:    reg_rdata = rbuf;
      default: reg_rdata = 8'h00;
    endcase
  end

  p_glitch_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == START && mid && vote) |=> st == IDLE);
  p_fe_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe) |-> ($past(fe_en) && $past(st) == STOP));
  p_fe_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fe && !wr_ctl) |=> fe);
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && fe_en) |=> $stable(mode_hi));
  p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(wr_ctl && !reg_wdata[0])) |=> done);
  p_stay_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && !enabled) |=> st == IDLE);
endmodule

// File: tb/uart_rx_fe_bench.sv
module uart_rx_fe_bench;
  logic clk = 1'b0, rst_n = 1'b0, rx_in = 1'b1, tick16 = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  int checks = 0, failures = 0;
  bit finished = 0;

  uart_rx_fe u_uart_rx_fe (.clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick16(tick16),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always #4 clk = ~clk;
  always @(posedge clk) tick16 <= ~tick16;

  // mode[12:11] fe_en[10] data[9:1] stop[0]
  localparam logic [12:0] VEC [7] = '{
    {2'b01, 1'b0, 9'h0A5, 1'b1},
    {2'b01, 1'b1, 9'h03C, 1'b1},
    {2'b01, 1'b1, 9'h081, 1'b0},
    {2'b10, 1'b0, 9'h1F0, 1'b1},
    {2'b11, 1'b1, 9'h055, 1'b0},
    {2'b01, 1'b0, 9'h07E, 1'b0},
    {2'b11, 1'b0, 9'h100, 1'b1}
  };

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic setup(logic [1:0] mode, logic fe_on);
    wr(1, 8'h00);
    wr(0, {mode, 2'b01, 4'b0000});
    wr(1, 8'h40);
    wr(0, {1'b0, mode[0], 2'b01, 4'b0000});
    wr(1, fe_on ? 8'h40 : 8'h00);
  endtask

  task automatic send(int nb, logic [8:0] d, logic stopb, int gbit, output logic early);
    logic [7:0] v;
    @(negedge clk); rx_in = 1'b0;
    repeat (31) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx_in = d[i];
      if (i == gbit) begin
        repeat (15) @(negedge clk); rx_in = ~d[i];
        repeat (2) @(negedge clk);  rx_in = d[i];
        repeat (15) @(negedge clk);
      end else repeat (32) @(negedge clk);
    end
    rx_in = stopb;
    repeat (7) @(negedge clk);
    rd(0, v); early = v[0];
    repeat (24) @(negedge clk);
    rx_in = 1'b1;
    repeat (64) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic early, exp_b8;
    exp_b8 = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    rd(0, v); chk("R1 ctrl", {1'b0, v}, 9'h000);
    rd(1, v); chk("R1 cfg",  {1'b0, v}, 9'h000);
    rd(2, v); chk("R1 data", {1'b0, v}, 9'h000);

    for (int k = 0; k < 7; k++) begin
      logic [1:0] md; logic fo; logic [8:0] d; logic sb;
      {md, fo, d, sb} = VEC[k];
      setup(md, fo);
      send(md[1] ? 9 : 8, d, sb, -1, early);
      if (md[1]) exp_b8 = d[8];
      chk("R6 done position", {8'b0, early}, {8'b0, !fo});
      rd(0, v);
      chk("R2 done", {8'b0, v[0]}, 9'h001);
      chk("R3 ninth bit", {8'b0, v[2]}, {8'b0, exp_b8});
      if (!fo) chk("R9 bit7 is mode", {8'b0, v[7]}, {8'b0, md[1]});
      rd(2, v);
      chk("R2 data", {1'b0, v}, {1'b0, d[7:0]});
      wr(1, 8'h40); rd(0, v);
      chk("R7 frame error", {8'b0, v[7]}, {8'b0, fo & !sb});
    end

    // R8 sticky flag
    setup(2'b01, 1'b1);
    send(8, 9'h0C3, 1'b0, -1, early);
    rd(0, v); chk("R8 set", {8'b0, v[7]}, 9'h001);
    send(8, 9'h012, 1'b1, -1, early);
    rd(0, v); chk("R8 kept by good frame", {8'b0, v[7]}, 9'h001);
    wr(0, 8'hD1);
    rd(0, v); chk("R8 write 1 no effect", {8'b0, v[7]}, 9'h001);
    wr(0, 8'h51);
    rd(0, v); chk("R8 write 0 clears", {8'b0, v[7]}, 9'h000);
    wr(0, 8'hD1);
    rd(0, v); chk("R8 write 1 no set", {8'b0, v[7]}, 9'h000);

    // R9 aliasing of bit 7
    setup(2'b11, 1'b1);
    wr(0, 8'h50);
    wr(1, 8'h00);
    rd(0, v); chk("R9 mode kept", {8'b0, v[7]}, 9'h001);
    wr(0, 8'h50);
    rd(0, v); chk("R9 mode writable", {8'b0, v[7]}, 9'h000);

    // R10 done flag
    setup(2'b01, 1'b0);
    send(8, 9'h011, 1'b1, -1, early);
    wr(0, 8'h51);
    rd(0, v); chk("R10 write 1 keeps", {8'b0, v[0]}, 9'h001);
    send(8, 9'h022, 1'b1, -1, early);
    rd(2, v); chk("R10 overwrite", {1'b0, v}, 9'h022);
    rd(0, v); chk("R10 still set", {8'b0, v[0]}, 9'h001);
    wr(0, 8'h50);
    rd(0, v); chk("R10 write 0 clears", {8'b0, v[0]}, 9'h000);
    wr(0, 8'h51);
    rd(0, v); chk("R10 write 1 no set", {8'b0, v[0]}, 9'h000);

    // R5 short start pulse
    @(negedge clk); rx_in = 1'b0;
    repeat (8) @(negedge clk); rx_in = 1'b1;
    repeat (400) @(negedge clk);
    rd(0, v); chk("R5 no done", {8'b0, v[0]}, 9'h000);
    rd(2, v); chk("R5 data kept", {1'b0, v}, 9'h022);

    // R4 one-sample disturbance
    setup(2'b01, 1'b0);
    send(8, 9'h05A, 1'b1, 3, early);
    rd(2, v); chk("R4 vote", {1'b0, v}, 9'h05A);
    send(8, 9'h0A5, 1'b1, 6, early);
    rd(2, v); chk("R4 vote", {1'b0, v}, 9'h0A5);

    // R11 disabled receiver
    wr(0, 8'h40);
    send(8, 9'h099, 1'b1, -1, early);
    rd(0, v); chk("R11 rx off", {8'b0, v[0]}, 9'h000);
    wr(0, 8'h10);
    send(8, 9'h066, 1'b1, -1, early);
    rd(0, v); chk("R11 mode 0", {8'b0, v[0]}, 9'h000);
    rd(2, v); chk("R11 data kept", {1'b0, v}, 9'h0A5);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule